// File: doc/BRIEF.md
# Page-Mode Nibble DRAM Sequencer

This block drives a dynamic RAM array that is four bits wide. It reads or writes one byte in each access slot of eight clock cycles. The nominal clock is 16 MHz, so each cycle is 62.5 ns and each slot is 500 ns. The byte travels as two nibbles. Both nibbles fall under a single row strobe, and each nibble gets its own column strobe. Row and column addresses share one multiplexed address bus, so the block sets each address up one cycle before the strobe edge that latches it.

A free-running three-bit phase counter starts at zero when reset is released and wraps every eight cycles. A requester presents a request (byte address, read/write flag, write byte) during phase 6. The block samples it at the end of that cycle. The row address goes out during phase 7, and the access fills phases 0 to 7 of the next slot. A request is taken every slot, so back-to-back accesses run with no gap. For a read, the assembled byte appears with a one-cycle valid pulse during phase 0 of the slot that follows the access.

Top module: `nibble_dram_seq`

## Requirements
- R1: After reset the phase counter reads 0 in the first cycle and advances by one each cycle, modulo 8. `req_valid` is sampled only at the end of phase 6. A request held in any other phase is ignored, and the slot after it stays idle.
- R2: During an accepted slot, `ras_n` is low in phases 0–3 and high in phases 4–7.
- R3: During an accepted slot, `cas_n` is low in phases 2, 3, 6 and 7 and high in phases 0, 1, 4 and 5.
- R4: The row latched at the falling edge of `ras_n` is byte address bits [14:7]. The first `cas_n` falling edge latches column {addr[6:0],0}, which is the low nibble. The second latches {addr[6:0],1}, which is the high nibble. Address bit 15 has no effect. The address bus is stable across every strobe falling edge.
- R5: For a write, `we_n` is low and `dram_dq` carries wdata[3:0] in phases 1–3, then wdata[7:4] in phases 5–7.
- R6: `dram_dq` is high-impedance in every cycle in which no write nibble is driven. `we_n` stays high during reads and idle slots.
- R7: For a read, the block samples the low nibble at the end of phase 3 and the high nibble at the end of phase 7. `rd_data` = {high,low} is presented with `rd_valid` high for exactly one cycle, in phase 0 of the next slot. `rd_valid` is low at all other times.
- R8: A slot with no accepted request keeps `ras_n`, `cas_n` and `we_n` high.
- R9: In reset, all strobes are high, `rd_valid` is low, `dram_addr` is 0 and `dram_dq` is high-impedance.
- R10: Requests accepted in consecutive slots produce contiguous accesses. The next row is on the address bus during phase 7 of the current slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock (eight cycles per slot) |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present (sampled in phase 6) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address; bit 15 ignored |
| req_wdata | input | 8 | Byte to write |
| dram_addr | output | 8 | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, low = write |
| dram_dq | inout | 4 | Nibble data bus |
| rd_data | output | 8 | Assembled read byte |
| rd_valid | output | 1 | One-cycle read-byte valid pulse |

## Verification
The hardest case to reach is a slot boundary where one access hands over to the next. In that case the column of the current access and the row of the following one share the address bus within two cycles. At the same moment, a read byte is assembled while a write nibble is being prepared. The bench reaches this case by issuing requests in consecutive slots, both directed and random (about 80% request density), with mixed reads and writes. A bus-model memory latches addresses on the strobe edges. Mapping errors and late address changes therefore appear in the data read back and in the latched row and column values.

// File: rtl/nibble_dram_seq.sv
module nibble_dram_seq #(
  parameter int RAW = 8,
  parameter int DW  = 4,
  parameter int AW  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [2*DW-1:0] req_wdata,
  output logic [RAW-1:0]  dram_addr,
  output logic            ras_n,
  output logic            cas_n,
  output logic            we_n,
  inout  wire  [DW-1:0]   dram_dq,
  output logic [2*DW-1:0] rd_data,
  output logic            rd_valid
);
  localparam int CW = RAW - 1;
  localparam int BW = 2 * DW;

  typedef struct packed {
    logic          v;
    logic          wr;
    logic [RAW-1:0] row;
    logic [CW-1:0]  col;
    logic [BW-1:0]  wd;
  } slot_t;

  logic [2:0] ph, np;
  slot_t      pend, act, nx, cur;
  logic       oe;
  logic [DW-1:0] wnib, lo_q;
  logic       unused_hi;

  assign unused_hi = ^req_addr[AW-1:2*RAW-1];
  assign np  = ph + 3'd1;
  assign nx  = '{v: req_valid, wr: req_write, row: req_addr[2*RAW-2 -: RAW],
                 col: req_addr[CW-1:0], wd: req_wdata};
  assign cur = (ph == 3'd7) ? pend : act;
  assign dram_dq = oe ? wnib : 'z;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= '0; pend <= '0; act <= '0;
      ras_n <= 1'b1; cas_n <= 1'b1; we_n <= 1'b1; oe <= 1'b0;
      wnib <= '0; lo_q <= '0; dram_addr <= '0; rd_data <= '0; rd_valid <= 1'b0;
    end else begin
      ph <= np;
      if (ph == 3'd6) pend <= nx;
      if (ph == 3'd7) act <= pend;
      ras_n <= !(cur.v && !np[2]);
      cas_n <= !(cur.v && np[1]);
      oe    <= cur.v && cur.wr && (np[1:0] != 2'd0);
      we_n  <= !(cur.v && cur.wr && (np[1:0] != 2'd0));
      wnib  <= np[2] ? cur.wd[BW-1:DW] : cur.wd[DW-1:0];
      if (np == 3'd7)      dram_addr <= nx.v ? nx.row : '0;
      else if (!cur.v)     dram_addr <= '0;
      else if (np == 3'd0) dram_addr <= cur.row;
      else                 dram_addr <= {cur.col, np[2]};
      if (ph == 3'd3 && act.v) lo_q <= dram_dq;
      rd_valid <= (ph == 3'd7) && act.v && !act.wr;
      if ((ph == 3'd7) && act.v && !act.wr) rd_data <= {dram_dq, lo_q};
    end
  end

  a_r2_ras_two_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |=> !ras_n);
  a_r3_cas_low_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |=> !cas_n);
  a_r3_cas_high_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |=> cas_n);
  a_r4_row_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $stable(dram_addr));
  a_r4_col_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> $stable(dram_addr));
  a_r5_we_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> $stable(we_n));
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
endmodule

// File: tb/test_nibble_dram_seq.sv
`timescale 1ns/1ps
module test_nibble_dram_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  dram_addr, rd_data;
  logic ras_n, cas_n, we_n, rd_valid;
  wire  [3:0]  dq;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  nibble_dram_seq i_nibble_dram_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .dram_addr(dram_addr),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .dram_dq(dq),
    .rd_data(rd_data), .rd_valid(rd_valid));

  // memory bus model
  logic [3:0] mem [int];
  logic       drv_en = 1'b0;
  logic [3:0] drv_val = '0;
  logic [7:0] lat_row = '0, lat_c0 = '0, lat_c1 = '0;
  assign dq = drv_en ? drv_val : 'z;

  function automatic logic [3:0] nib(input int k);
    if (mem.exists(k)) return mem[k];
    return 4'(k) ^ 4'(k >> 4) ^ 4'(k >> 8) ^ 4'(k >> 12) ^ 4'h5;
  endfunction

  always @(negedge ras_n) begin #1; lat_row = dram_addr; end
  always @(negedge cas_n) begin
    #1;
    if (!ras_n) lat_c0 = dram_addr; else lat_c1 = dram_addr;
    if (!we_n) mem[{16'd0, lat_row, dram_addr}] = dq;
    else begin drv_val = nib({16'd0, lat_row, dram_addr}); drv_en = 1'b1; end
  end
  always @(posedge cas_n) begin #1; drv_en = 1'b0; end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", r, act, exp, $time);
    end
  endtask

  // slot tracking derived from the requirements
  typedef struct packed { logic v; logic wr; logic [15:0] a; logic [7:0] d; } bslot_t;
  logic [2:0] bph = '0;
  bslot_t bp = '0, ba = '0, blast = '0;
  logic [7:0] s_row = '0, s_c0 = '0, s_c1 = '0;

  always @(posedge clk) begin
    if (!rst_n) begin bph <= '0; bp <= '0; ba <= '0; blast <= '0; end
    else begin
      bph <= bph + 3'd1;
      if (bph == 3'd6) bp <= '{req_valid, req_write, req_addr, req_wdata};
      if (bph == 3'd7) begin ba <= bp; blast <= ba; end
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(ras_n && cas_n && we_n, "R9 strobes", {ras_n, cas_n, we_n}, 7);
      chk(!rd_valid && dram_addr == 0, "R9 outputs", {rd_valid, dram_addr}, 0);
      chk(dq === 4'bzzzz, "R9 dq", dq, 0);
    end else begin
      logic wwin, e_ras, e_cas;
      e_ras = !(ba.v && bph <= 3'd3);
      e_cas = !(ba.v && bph[1]);
      wwin  = ba.v && ba.wr && (bph[1:0] != 2'd0);
      if (ba.v) begin
        chk(ras_n == e_ras, "R2 ras_n", ras_n, e_ras);
        chk(cas_n == e_cas, "R3 cas_n", cas_n, e_cas);
      end else
        chk(ras_n && cas_n && we_n, "R8/R1 idle strobes", {ras_n, cas_n, we_n}, 7);
      if (wwin) begin
        chk(!we_n, "R5 we_n", we_n, 0);
        chk(dq === (bph[2] ? ba.d[7:4] : ba.d[3:0]), "R5 dq nibble", dq,
            bph[2] ? ba.d[7:4] : ba.d[3:0]);
      end else begin
        chk(we_n, "R6 we_n high", we_n, 1);
        if (!drv_en) chk(dq === 4'bzzzz, "R6 dq released", dq, 0);
      end
      if (bph == 3'd7) begin
        s_row = lat_row; s_c0 = lat_c0; s_c1 = lat_c1;
        if (bp.v) chk(dram_addr == bp.a[14:7], "R10 next row early", dram_addr, bp.a[14:7]);
      end
      if (bph == 3'd0 && blast.v) begin
        int k0, k1;
        k0 = {16'd0, blast.a[14:7], blast.a[6:0], 1'b0};
        k1 = k0 | 1;
        chk(s_row == blast.a[14:7], "R4 row", s_row, blast.a[14:7]);
        chk(s_c0 == {blast.a[6:0], 1'b0}, "R4 col low", s_c0, {blast.a[6:0], 1'b0});
        chk(s_c1 == {blast.a[6:0], 1'b1}, "R4 col high", s_c1, {blast.a[6:0], 1'b1});
        if (blast.wr) begin
          chk(rd_valid == 1'b0, "R7 no valid on write", rd_valid, 0);
          chk({nib(k1), nib(k0)} == blast.d, "R5 stored byte", {nib(k1), nib(k0)}, blast.d);
        end else begin
          chk(rd_valid == 1'b1, "R7 valid pulse", rd_valid, 1);
          chk(rd_data == {nib(k1), nib(k0)}, "R7 read byte", rd_data, {nib(k1), nib(k0)});
        end
      end else
        chk(rd_valid == 1'b0, "R7 valid only in phase 0", rd_valid, 0);
    end
  end

  task automatic issue(input bit v, input bit wr, input logic [15:0] a, input logic [7:0] d);
    while (bph != 3'd6) @(negedge clk);
    req_valid = v; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_addr = 16'($urandom); req_wdata = 8'($urandom);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 counter starts at 0: first request launched six cycles after release
    issue(1, 1, 16'h1234, 8'hA5);
    issue(1, 0, 16'h1234, 8'h00);
    // R4: bit 15 ignored
    issue(1, 1, 16'h9234, 8'h3C);
    issue(1, 0, 16'h1234, 8'h00);
    issue(1, 0, 16'hFFFF, 8'h00);
    issue(1, 1, 16'h0000, 8'hFF);
    issue(1, 0, 16'h8000, 8'h00);
    // R1: request held outside phase 6 is ignored
    while (bph != 3'd0) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h1234; req_wdata = 8'h00;
    while (bph != 3'd5) @(negedge clk);
    req_valid = 1'b0;
    repeat (10) @(negedge clk);
    issue(1, 0, 16'h1234, 8'h00);
    // R8 idle slot then R10 back-to-back mix
    issue(0, 0, 16'h0000, 8'h00);
    for (int i = 0; i < 300; i++) begin
      logic [15:0] a;
      a = ($urandom % 4 == 0) ? {8'h00, 6'd0, 2'($urandom)} : 16'($urandom);
      issue(($urandom % 5) != 0, $urandom % 2, a, 8'($urandom));
    end
    repeat (20) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule